// File: doc/BRIEF.md
# Loss-of-Signal Interrupt Register Bank

This block collects one loss-of-signal level from each of eight line channels and presents them to a host processor through three small registers: a per-channel interrupt mask, a sticky record of channels whose condition has changed, and a live view of the present condition. One interrupt line goes to the host. It stays asserted while any recorded change is also unmasked.

The alarm levels come from analog detectors that do not share the host clock, so each one is resynchronized before use. Any transition of a synchronized level, into alarm or out of it, sets that channel's sticky bit. The service routine first reads the sticky register to find the channels that raised the interrupt. It then reads the live register to see the present state. That second read acknowledges the interrupt and clears every sticky bit. A change that arrives in the same cycle as the acknowledging read survives it.

Top module: `los_irq_bank`

## Requirements
- R1: After reset the mask, sticky and live registers all read 0x00 and `irq` is low.
- R2: A write to address 0 loads the 8-bit mask. Bit n enables channel n alone, 0xFF enables all eight, and address 0 reads the mask back.
- R3: Address 2 returns the live alarm levels, bit n for channel n. A level applied to `los_in` appears there after the second rising clock edge.
- R4: Address 1 returns the sticky register. A rising or a falling transition of a channel's live level sets that channel's bit at the next clock edge.
- R5: A read of address 1 leaves the sticky register unchanged.
- R6: A read of address 2 clears every sticky bit at the clock edge that ends the read.
- R7: If a channel's transition is being recorded in the same cycle as a read of address 2, that channel's sticky bit stays set and the other bits clear.
- R8: `irq` is high exactly when some bit is set in both the sticky register and the mask. A sticky bit whose mask bit is 0 leaves `irq` low.
- R9: Writes to addresses 1, 2 and 3 change no register, and address 3 reads 0x00.
- R10: A sticky bit stays set after its channel returns to its earlier level, until a read of address 2 clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| los_in | input | 8 | Asynchronous loss-of-signal level, one bit per channel |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register select: 0 mask, 1 sticky, 2 live, 3 unused |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt request to the host |

## Verification
The acknowledging read of the live register can fall in the same cycle as the recording of a new channel transition. These two operations pull the sticky register in opposite directions. The bench provokes the overlap by first leaving one channel's bit pending, then changing a second channel's input and timing the live read two edges later, so that it lands on the cycle in which the transition is recorded. The next read of the sticky register must show only the new channel's bit. A behavioural model runs on every clock as well and judges every overlap that the random phase produces.

// File: rtl/los_irq_bank.sv
module los_irq_bank #(
  parameter int NCH = 8,
  parameter int AW  = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] los_in,
  input  logic           bus_sel,
  input  logic           bus_wr,
  input  logic [AW-1:0]  bus_addr,
  input  logic [NCH-1:0] bus_wdata,
  output logic [NCH-1:0] bus_rdata,
  output logic           irq
);
  localparam logic [AW-1:0] A_MASK = AW'(0);
  localparam logic [AW-1:0] A_PEND = AW'(1);
  localparam logic [AW-1:0] A_LIVE = AW'(2);

  logic [NCH-1:0] sync_a, live, live_q, mask, pend;
  logic [NCH-1:0] change;
  logic           wr_mask, rd_live;

  assign wr_mask = bus_sel &&  bus_wr && bus_addr == A_MASK;
  assign rd_live = bus_sel && !bus_wr && bus_addr == A_LIVE;
  assign change  = live ^ live_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_a <= '0;
      live   <= '0;
      live_q <= '0;
    end else begin
      sync_a <= los_in;
      live   <= sync_a;
      live_q <= live;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       mask <= '0;
    else if (wr_mask) mask <= bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else        pend <= (rd_live ? '0 : pend) | change;
  end

  always_comb begin
    case (bus_addr)
      A_MASK:  bus_rdata = mask;
      A_PEND:  bus_rdata = pend;
      A_LIVE:  bus_rdata = live;
      default: bus_rdata = '0;
    endcase
  end

  assign irq = |(pend & mask);

  AST_LIVE_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rst_n, 2)) |-> live == $past(los_in, 2)); // R3
  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |=> mask == $past(bus_wdata)); // R2
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mask |=> $stable(mask)); // R9
  AST_EDGE_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (($past(live) ^ $past(live_q)) & ~pend) == '0); // R4
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(rd_live)) |-> (pend & $past(pend)) == $past(pend)); // R10
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_live |=> (pend & ~$past(change)) == '0); // R6
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq); // R8
endmodule

// File: tb/los_irq_bank_test.sv
module los_irq_bank_test;
  logic       clk = 0, rst_n = 0;
  logic [7:0] los_in = 0, bus_wdata = 0;
  logic       bus_sel = 0, bus_wr = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_rdata;
  logic       irq;
  int checks = 0, fails = 0;

  los_irq_bank uut (.clk(clk), .rst_n(rst_n), .los_in(los_in), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq));

  always #10 clk = ~clk;

  // behavioural reference: history of sampled inputs, newest first
  int hist[$];
  int m_mask, m_pend;
  initial begin hist = {0, 0, 0}; m_mask = 0; m_pend = 0; end

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = {0, 0, 0}; m_mask = 0; m_pend = 0;
    end else begin
      int nxt;
      nxt = (bus_sel && !bus_wr && bus_addr == 2) ? 0 : m_pend;
      nxt = nxt | (hist[1] ^ hist[2]);
      m_pend = nxt;
      if (bus_sel && bus_wr && bus_addr == 0) m_mask = bus_wdata;
      hist.push_front(int'(los_in));
      void'(hist.pop_back());
    end
  end

  function automatic int model_read(input int a);
    case (a)
      0: return m_mask;
      1: return m_pend;
      2: return hist[1];
      default: return 0;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    case (bus_addr)
      0: check("R2 mask readback", bus_rdata, model_read(0));
      1: check("R4 sticky register", bus_rdata, model_read(1));
      2: check("R3 live register", bus_rdata, model_read(2));
      default: check("R9 unused address", bus_rdata, 0);
    endcase
    check("R8 irq", irq, ((m_pend & m_mask) != 0) ? 1 : 0);
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic rd(input int a, output int d);
    step(); bus_sel = 1; bus_wr = 0; bus_addr = 2'(a);
    @(negedge clk); d = bus_rdata;
    @(posedge clk); #2; bus_sel = 0;
  endtask

  task automatic wr(input int a, input int v);
    step(); bus_sel = 1; bus_wr = 1; bus_addr = 2'(a); bus_wdata = 8'(v);
    @(posedge clk); #2; bus_sel = 0; bus_wr = 0;
  endtask

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #3000000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    int d;
    wait_cycles(3);
    rst_n = 1;
    @(negedge clk);
    check("R1 irq after reset", irq, 0);
    rd(0, d); check("R1 mask reset", d, 0);
    rd(1, d); check("R1 sticky reset", d, 0);
    rd(2, d); check("R1 live reset", d, 0);

    wr(0, 8'h01); rd(0, d); check("R2 per-channel mask", d, 8'h01);

    step(); los_in = 8'h01; wait_cycles(4);
    rd(1, d); check("R4 rising edge sets bit", d, 8'h01);
    @(negedge clk); check("R8 irq enabled", irq, 1);
    rd(1, d); check("R5 sticky read keeps bits", d, 8'h01);
    rd(2, d); check("R3 live shows alarm", d, 8'h01);
    rd(1, d); check("R6 live read clears", d, 8'h00);
    @(negedge clk); check("R8 irq cleared", irq, 0);

    step(); los_in = 8'h00; wait_cycles(4);
    rd(1, d); check("R4 falling edge sets bit", d, 8'h01);
    wait_cycles(10);
    rd(1, d); check("R10 bit sticky after return", d, 8'h01);
    rd(2, d); check("R3 live shows clear", d, 8'h00);

    step(); los_in = 8'h08; wait_cycles(4);
    rd(1, d); check("R4 masked channel recorded", d, 8'h08);
    @(negedge clk); check("R8 masked bit keeps irq low", irq, 0);

    step(); los_in = 8'h0C; @(posedge clk); #2;
    rd(2, d);
    rd(1, d); check("R7 concurrent change survives clear", d, 8'h04);
    rd(2, d); rd(1, d); check("R6 clear after overlap", d, 8'h00);

    wr(1, 8'hFF); wr(2, 8'hFF); wr(3, 8'hFF);
    rd(0, d); check("R9 writes elsewhere ignored", d, 8'h01);
    rd(1, d); check("R9 sticky not writable", d, 8'h00);
    rd(3, d); check("R9 address 3 reads zero", d, 8'h00);

    wr(0, 8'hFF); rd(0, d); check("R2 enable all", d, 8'hFF);

    for (int i = 0; i < 600; i++) begin
      step();
      if ($urandom_range(0, 3) == 0) los_in = 8'($urandom);
      bus_sel = ($urandom_range(0, 2) == 0);
      bus_wr = ($urandom_range(0, 5) == 0);
      bus_addr = 2'($urandom);
      bus_wdata = 8'($urandom);
    end
    step(); bus_sel = 0; bus_wr = 0;
    wait_cycles(3);
    summary();
    $finish;
  end
endmodule